// File: doc/BRIEF.md
# Programmable Receive Frame Parser

The parser classifies each incoming Ethernet frame against an ordered table of rules. Frame contents arrive as a stream of 32-bit words, with the first beat of a frame as word 0. Each rule picks one word by its word offset and compares it against stored match data under a per-bit enable mask. A rule that matches can accept the frame to a DMA channel or drop it. A rule can also be marked as continuing, so that it only counts when the rule after it also matches. This lets one field that straddles a word boundary be covered by two consecutive rules: the first rule covers the upper bytes of word N and the follow-on rule covers the lower bytes of word N+1.

Every rule tracks its own hit state while the words stream past, so no frame buffer is needed. When the last word arrives, the rule outcomes are resolved in ascending index order and a single decision pulse is issued. Software fills the table through a small write port, and only while no frame is in progress. After reset the table is empty except for its final rule, a match-all accept to channel 0, so every frame gets a decision.

Top module: `prs_frame_parser`

## Requirements
- R1: After reset `dec_valid` is low and every rule is cleared, except the last rule (index DEPTH-1), which has an all-zero mask, the accept flag set and channel 0. With this table a frame is accepted to channel 0.
- R2: A rule hits when the frame's word at the rule's offset satisfies ((word XOR data) AND mask) == 0. Beat k of a frame is word k.
- R3: A rule whose mask is all zeros matches every frame, including a one-word frame.
- R4: The deciding rule with its accept flag set gives `dec_accept`=1 and `dec_chan` = its channel. With its reject flag set it gives `dec_accept`=0 and `dec_chan`=0. Reject wins when both flags are set.
- R5: Rules are tried in ascending index order. The first completed match whose rule has accept or reject set decides the frame. A matching rule with neither flag set is passed over.
- R6: A rule with its continue flag set never decides by itself. The next rule completes the chain only if both match, and the action of the last rule in the chain applies.
- R7: When any rule of a chain fails, the whole chain fails and evaluation resumes at the first rule after the chain, even if later chain members match on their own.
- R8: A rule with a non-zero mask does not match if the frame ended before its word, or if its offset exceeds MAX_OFF_BYTES/4 (word 16 with the defaults).
- R9: `dec_valid` is high for exactly the one cycle after the clock edge that takes in the beat with `s_last` set, and is low at all other times.
- R10: Writes to the table are ignored while a frame is open (from its first beat up to and including its last beat, gaps included) and whenever `s_valid` is high.
- R11: A write puts `cfg_wdata` into the rule `cfg_idx`, with `cfg_sel` selecting the field: 0 = match data, 1 = mask, 2 = control, 3 = no effect. Control bits: [7:0] word offset, [8] accept, [9] reject, [10] continue, [16+CHW-1:16] channel.
- R12: If no rule decides, the frame is dropped: `dec_accept`=0 and `dec_chan`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Frame word valid |
| s_data | input | 32 | Frame word |
| s_last | input | 1 | Marks the final word of a frame |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(DEPTH) | Rule index to write |
| cfg_sel | input | 2 | Field select |
| cfg_wdata | input | 32 | Write data |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | 1 = accept, 0 = drop |
| dec_chan | output | CHW | DMA channel for an accepted frame |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Chains where the head matches but the tail fails, and chains where the tail matches but the head fails. A broken chain would either leak the tail's action or swallow the next independent rule.
- Frames shorter than a rule's offset, and offsets past the inspectable limit. A wrong design would accept on a word it never saw.
- Zero-mask rules on one-word frames, and a table whose final rule has been cleared. These expose a decision that is missing, or one that defaults to accept.
- A write issued in the same cycle as a frame beat, and another in a gap inside a frame. If either write lands, the following frame takes the wrong action.

// File: rtl/prs_pkg.sv
// Package: shared constants for the frame parser.
// Holds the write-port field selects and the bit positions of the control word.
package prs_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    localparam int CTL_OFF_LSB = 0;
    localparam int CTL_OFF_W   = 8;
    localparam int CTL_ACC_BIT = 8;
    localparam int CTL_REJ_BIT = 9;
    localparam int CTL_CON_BIT = 10;
    localparam int CTL_CH_LSB  = 16;
endpackage

// File: rtl/prs_rule_entry.sv
// Module: one rule of the parser table.
// Stores the match data, mask, offset, flags and channel of one rule, and
// follows the rule's hit state while the frame words stream past.
// Assumes: wr_en is already qualified by index and idle state; beat_idx is the
// word number of the current beat; beat_first marks word 0 of a frame.
module prs_rule_entry
    import prs_pkg::*;
#(
    parameter int CHW        = 4,
    parameter int MAX_WORD   = 16,
    parameter bit LAST_ENTRY = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [31:0]    wr_data,
    input  logic           beat_valid,
    input  logic           beat_first,
    input  logic [7:0]     beat_idx,
    input  logic [31:0]    beat_word,
    output logic           match_o,
    output logic           cont_o,
    output logic           acc_o,
    output logic           rej_o,
    output logic [CHW-1:0] chan_o
);
    logic [31:0]    data_q;
    logic [31:0]    mask_q;
    logic [7:0]     off_q;
    logic           acc_q;
    logic           rej_q;
    logic           cont_q;
    logic [CHW-1:0] chan_q;
    logic           hit_q;
    logic           cmp_now;

    // Table storage: reset to empty, or to match-all accept for the last rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
            off_q  <= '0;
            acc_q  <= LAST_ENTRY;
            rej_q  <= 1'b0;
            cont_q <= 1'b0;
            chan_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_DATA: data_q <= wr_data;
                SEL_MASK: mask_q <= wr_data;
                SEL_CTRL: begin
                    off_q  <= wr_data[CTL_OFF_LSB +: CTL_OFF_W];
                    acc_q  <= wr_data[CTL_ACC_BIT];
                    rej_q  <= wr_data[CTL_REJ_BIT];
                    cont_q <= wr_data[CTL_CON_BIT];
                    chan_q <= wr_data[CTL_CH_LSB +: CHW];
                end
                default: ;
            endcase
        end
    end

    // Word compare: the beat is this rule's word, in range, and equal under the mask.
    always_comb begin
        cmp_now = beat_valid && (beat_idx == off_q) && (int'(beat_idx) <= MAX_WORD)
                  && (((beat_word ^ data_q) & mask_q) == 32'd0);
    end

    // Hit tracking: restart on word 0, otherwise accumulate over the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          hit_q <= 1'b0;
        else if (beat_valid) hit_q <= cmp_now | (!beat_first & hit_q);
    end

    // Match including the current beat; a zero mask matches unconditionally.
    always_comb begin
        match_o = (mask_q == 32'd0) | cmp_now | (!beat_first & hit_q);
        cont_o  = cont_q;
        acc_o   = acc_q;
        rej_o   = rej_q;
        chan_o  = chan_q;
    end

    AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !beat_valid); // R10
    AST_HIT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_q) |-> $past(beat_valid)); // R2
endmodule

// File: rtl/prs_resolve.sv
// Module: chain and priority resolution across all rules.
// Walks the rules in ascending order, tracks continue chains, and reports the
// first rule that completes a match with an action.
// Assumes: match/flag vectors are indexed by rule number; channels are packed CHW apart.
module prs_resolve #(
    parameter int DEPTH = 64,
    parameter int CHW   = 4
) (
    input  logic [DEPTH-1:0]     match_v,
    input  logic [DEPTH-1:0]     cont_v,
    input  logic [DEPTH-1:0]     acc_v,
    input  logic [DEPTH-1:0]     rej_v,
    input  logic [DEPTH*CHW-1:0] chan_v,
    output logic                 found_o,
    output logic                 accept_o,
    output logic [CHW-1:0]       chan_o
);
    // Ordered scan: a rule completes only if its chain predecessors all matched.
    always_comb begin
        logic prev_cont;
        logic prev_ok;
        logic ok;
        prev_cont = 1'b0;
        prev_ok   = 1'b1;
        found_o   = 1'b0;
        accept_o  = 1'b0;
        chan_o    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ok = match_v[i] && (!prev_cont || prev_ok);
            if (!found_o && ok && !cont_v[i] && (acc_v[i] || rej_v[i])) begin
                found_o  = 1'b1;
                accept_o = !rej_v[i];
                chan_o   = rej_v[i] ? '0 : chan_v[i*CHW +: CHW];
            end
            prev_cont = cont_v[i];
            prev_ok   = ok;
        end
    end
endmodule

// File: rtl/prs_frame_parser.sv
// Module: top of the programmable receive frame parser.
// Counts frame words, gates table writes to idle time, instantiates the rule
// table and registers one decision per frame.
// Assumes: a frame is a run of s_valid beats ending with s_last; gaps allowed.
module prs_frame_parser #(
    parameter int DEPTH         = 64,
    parameter int MAX_OFF_BYTES = 64,
    parameter int CHW           = 4,
    localparam int IDXW         = $clog2(DEPTH),
    localparam int MAX_WORD     = MAX_OFF_BYTES / 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s_valid,
    input  logic [31:0]     s_data,
    input  logic            s_last,
    input  logic            cfg_we,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic [1:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    output logic            dec_valid,
    output logic            dec_accept,
    output logic [CHW-1:0]  dec_chan
);
    logic                 in_frame_q;
    logic [7:0]           cnt_q;
    logic [7:0]           beat_idx;
    logic                 wr_ok;
    logic [DEPTH-1:0]     match_v;
    logic [DEPTH-1:0]     cont_v;
    logic [DEPTH-1:0]     acc_v;
    logic [DEPTH-1:0]     rej_v;
    logic [DEPTH*CHW-1:0] chan_v;
    logic                 found;
    logic                 res_acc;
    logic [CHW-1:0]       res_chan;

    // Beat numbering and write gating.
    always_comb begin
        beat_idx = in_frame_q ? cnt_q : 8'd0;
        wr_ok    = cfg_we && !in_frame_q && !s_valid;
    end

    // Frame tracking: open on the first beat, close on the last, word count saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cnt_q      <= 8'd0;
        end else if (s_valid) begin
            in_frame_q <= !s_last;
            if (s_last)                       cnt_q <= 8'd0;
            else if (int'(beat_idx) <= MAX_WORD) cnt_q <= beat_idx + 8'd1;
        end
    end

    // Rule table: one entry per index, the last preloaded as match-all accept.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rule
        prs_rule_entry #(
            .CHW       (CHW),
            .MAX_WORD  (MAX_WORD),
            .LAST_ENTRY(g == DEPTH - 1)
        ) u_rule (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_ok && (cfg_idx == IDXW'(g))),
            .wr_sel    (cfg_sel),
            .wr_data   (cfg_wdata),
            .beat_valid(s_valid),
            .beat_first(!in_frame_q),
            .beat_idx  (beat_idx),
            .beat_word (s_data),
            .match_o   (match_v[g]),
            .cont_o    (cont_v[g]),
            .acc_o     (acc_v[g]),
            .rej_o     (rej_v[g]),
            .chan_o    (chan_v[g*CHW +: CHW])
        );
    end

    prs_resolve #(.DEPTH(DEPTH), .CHW(CHW)) u_resolve (
        .match_v (match_v),
        .cont_v  (cont_v),
        .acc_v   (acc_v),
        .rej_v   (rej_v),
        .chan_v  (chan_v),
        .found_o (found),
        .accept_o(res_acc),
        .chan_o  (res_chan)
    );

    // Decision register: one-cycle pulse after the last beat; no decider means drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_chan   <= '0;
        end else begin
            dec_valid <= s_valid && s_last;
            if (s_valid && s_last) begin
                dec_accept <= found && res_acc;
                dec_chan   <= (found && res_acc) ? res_chan : '0;
            end
        end
    end

    AST_DEC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(s_valid && s_last)); // R9
    AST_DROP_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> (dec_chan == '0)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= MAX_WORD + 1); // R8
    AST_WRITE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_q && cfg_we) |-> !wr_ok); // R10
endmodule

// File: tb/sim_prs_frame_parser.sv
module sim_prs_frame_parser;
    localparam int DEPTH = 64;
    localparam int MAXW  = 16;
    localparam int CHW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            s_valid = 1'b0;
    logic [31:0]     s_data = '0;
    logic            s_last = 1'b0;
    logic            cfg_we = 1'b0;
    logic [5:0]      cfg_idx = '0;
    logic [1:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            dec_valid;
    logic            dec_accept;
    logic [CHW-1:0]  dec_chan;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] sh_data [DEPTH];
    logic [31:0] sh_mask [DEPTH];
    logic [31:0] sh_ctl  [DEPTH];
    logic [31:0] fw [32];
    logic        exp_acc;
    logic [CHW-1:0] exp_ch;

    always #5 clk = ~clk;

    prs_frame_parser #(.DEPTH(DEPTH), .MAX_OFF_BYTES(64), .CHW(CHW)) u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_chan(dec_chan)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input int off, input bit acc, input bit rej,
                                           input bit con, input int ch);
        return (32'(ch) << 16) | (32'(con) << 10) | (32'(rej) << 9) | (32'(acc) << 8)
               | 32'(off & 8'hFF);
    endfunction

    // Reference model built from the requirements.
    task automatic ref_decide(input int len);
        bit prev_cont = 0, prev_ok = 1, found = 0, ok, hit;
        int off;
        exp_acc = 0; exp_ch = '0;
        for (int i = 0; i < DEPTH; i++) begin
            off = int'(sh_ctl[i][7:0]);
            hit = (sh_mask[i] == 0) ||
                  (off < len && off <= MAXW && (((fw[off] ^ sh_data[i]) & sh_mask[i]) == 0));
            ok = hit && (!prev_cont || prev_ok);
            if (!found && ok && !sh_ctl[i][10] && (sh_ctl[i][8] || sh_ctl[i][9])) begin
                found = 1;
                exp_acc = !sh_ctl[i][9];
                exp_ch  = sh_ctl[i][9] ? '0 : sh_ctl[i][16 +: CHW];
            end
            prev_cont = sh_ctl[i][10];
            prev_ok = ok;
        end
    endtask

    task automatic wr(input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 6'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (sel == 0) sh_data[idx] = d;
        else if (sel == 1) sh_mask[idx] = d;
        else if (sel == 2) sh_ctl[idx] = d;
    endtask

    task automatic set_rule(input int idx, input logic [31:0] d, input logic [31:0] m,
                            input logic [31:0] c);
        wr(idx, 0, d); wr(idx, 1, m); wr(idx, 2, c);
    endtask

    task automatic clear_rules(input int n);
        for (int i = 0; i < n; i++) set_rule(i, 0, 0, 0);
    endtask

    task automatic send(input int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            s_valid = 1; s_data = fw[k]; s_last = (k == len - 1);
        end
        @(negedge clk);
        s_valid = 0; s_last = 0;
    endtask

    task automatic run_frame(input string tag, input int len);
        ref_decide(len);
        send(len);
        chk({tag, " dec_valid"}, 32'(dec_valid), 1);
        chk({tag, " accept"}, 32'(dec_accept), 32'(exp_acc));
        chk({tag, " chan"}, 32'(dec_chan), 32'(exp_ch));
    endtask

    initial begin
        void'($urandom(32'd4177));
        for (int i = 0; i < DEPTH; i++) begin
            sh_data[i] = 0; sh_mask[i] = 0; sh_ctl[i] = 0;
        end
        sh_ctl[DEPTH-1] = mk_ctl(0, 1, 0, 0, 0);
        for (int k = 0; k < 32; k++) fw[k] = 32'(k) * 32'h01010101;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset dec_valid", 32'(dec_valid), 0);
        run_frame("R1 default table", 4);

        // R9: pulse lasts one cycle
        @(negedge clk);
        chk("R9 pulse single cycle", 32'(dec_valid), 0);

        // R2 / R11 exact word compare at offset 2
        set_rule(0, 32'hAABBCCDD, 32'hFFFFFFFF, mk_ctl(2, 1, 0, 0, 3));
        fw[2] = 32'hAABBCCDD;
        run_frame("R2 R11 match", 5);
        chk("R2 chan 3", 32'(dec_chan), 3);
        fw[2] = 32'hAABBCCDC;
        run_frame("R2 one bit off", 5);
        chk("R2 fallback chan", 32'(dec_chan), 0);
        // masked bit ignored
        wr(0, 1, 32'hFFFFFFFE);
        run_frame("R2 masked bit", 5);
        chk("R2 masked chan", 32'(dec_chan), 3);
        fw[2] = 32'hAABBCCDD;

        // R4 reject, then both flags
        wr(0, 2, mk_ctl(2, 0, 1, 0, 7));
        run_frame("R4 reject", 5);
        chk("R4 drop", 32'(dec_accept), 0);
        wr(0, 2, mk_ctl(2, 1, 1, 0, 7));
        run_frame("R4 both flags", 5);
        chk("R4 both drop", 32'(dec_accept), 0);

        // R5 priority and pass-over
        clear_rules(4);
        set_rule(0, 0, 0, mk_ctl(0, 0, 0, 0, 9));
        set_rule(1, 0, 0, mk_ctl(0, 1, 0, 0, 2));
        set_rule(2, 0, 0, mk_ctl(0, 1, 0, 0, 7));
        run_frame("R5 first wins", 3);
        chk("R5 chan 2", 32'(dec_chan), 2);

        // R6 / R7 chains
        clear_rules(4);
        fw[1] = 32'h11223344; fw[2] = 32'h55667788;
        set_rule(0, 32'h11220000, 32'hFFFF0000, mk_ctl(1, 1, 0, 1, 9));
        set_rule(1, 32'h00007788, 32'h0000FFFF, mk_ctl(2, 1, 0, 0, 6));
        set_rule(2, 0, 0, mk_ctl(0, 1, 0, 0, 4));
        run_frame("R6 chain both", 4);
        chk("R6 tail action", 32'(dec_chan), 6);
        fw[1] = 32'h99223344;
        run_frame("R7 head fails", 4);
        chk("R7 skip chain", 32'(dec_chan), 4);
        fw[1] = 32'h11223344; fw[2] = 32'h55667789;
        run_frame("R6 tail fails", 4);
        chk("R6 tail miss", 32'(dec_chan), 4);
        fw[2] = 32'h55667788;

        // R8 short frame and out-of-range offset
        clear_rules(4);
        fw[5] = 32'hCAFEF00D;
        set_rule(0, 32'hCAFEF00D, 32'hFFFFFFFF, mk_ctl(5, 1, 0, 0, 1));
        run_frame("R8 short frame", 3);
        chk("R8 short chan", 32'(dec_chan), 0);
        run_frame("R8 long frame", 8);
        chk("R8 long chan", 32'(dec_chan), 1);
        fw[17] = 32'hDEADBEEF;
        set_rule(0, 32'hDEADBEEF, 32'hFFFFFFFF, mk_ctl(17, 1, 0, 0, 1));
        run_frame("R8 beyond limit", 20);
        chk("R8 beyond chan", 32'(dec_chan), 0);

        // R3 zero mask on one-word frame
        set_rule(0, 32'h12345678, 0, mk_ctl(9, 0, 1, 0, 0));
        run_frame("R3 zero mask", 1);
        chk("R3 drop", 32'(dec_accept), 0);

        // R12 last rule cleared
        clear_rules(1);
        wr(DEPTH - 1, 2, 0);
        run_frame("R12 no decider", 2);
        chk("R12 drop", 32'(dec_accept), 0);
        wr(DEPTH - 1, 2, mk_ctl(0, 1, 0, 0, 0));

        // R10 writes during a frame are ignored
        set_rule(0, 0, 0, mk_ctl(0, 1, 0, 0, 5));
        @(negedge clk);
        s_valid = 1; s_data = fw[0]; s_last = 0;
        cfg_we = 1; cfg_idx = 0; cfg_sel = 2; cfg_wdata = mk_ctl(0, 0, 1, 0, 0);
        @(negedge clk);
        s_valid = 0;
        cfg_wdata = mk_ctl(0, 1, 0, 0, 11);
        @(negedge clk);
        cfg_we = 0;
        s_valid = 1; s_data = fw[1]; s_last = 1;
        @(negedge clk);
        s_valid = 0; s_last = 0;
        chk("R10 frame decided", 32'(dec_chan), 5);
        run_frame("R10 write ignored", 2);
        chk("R10 chan kept", 32'(dec_chan), 5);

        // Random tables and frames
        for (int t = 0; t < 15; t++) begin
            for (int i = 0; i < 12; i++) begin
                logic [31:0] m, d;
                int sh;
                sh = int'($urandom % 4);
                m = ($urandom % 6 == 0) ? 32'd0 : (32'hFF << (8 * sh));
                d = 32'($urandom % 4) * 32'h01010101;
                set_rule(i, d, m, mk_ctl(int'($urandom % 19), 1'($urandom), 1'($urandom),
                                         ($urandom % 3 == 0), int'($urandom % 16)));
            end
            for (int f = 0; f < 15; f++) begin
                int len;
                len = 1 + int'($urandom % 20);
                for (int k = 0; k < 32; k++) fw[k] = 32'($urandom % 4) * 32'h01010101;
                run_frame("R2 R5 R6 R7 R8 random", len);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule